// File: doc/BRIEF.md
# Dual-Bank Fractional Clock-Enable Divider

This block derives a slower clock-enable stream from its own clock. Each cycle of the source clock is first thinned by an integer pre-divider (1 to 4). Each surviving tick then adds M to an accumulator that wraps modulo N. Every wrap raises a one-cycle enable pulse. The average pulse rate is therefore `f_src / pre * M / N`. For example, a 384 MHz source with pre 1 and M/N = 3/625 gives 1.8432 MHz. With pre 4 and M/N = 1/6 it gives 16 MHz.

Two configuration banks each hold M, N, a pre-divider code and a hold bit. A select register names the bank software wants. The running bank changes only at a pulse boundary, so the output never has a partial period. Software may only program the bank that is not running. When N is zero the fractional stage is bypassed, and every pre-divider tick becomes a pulse.

Top module: `frac_clk_div`

## Requirements
- R1: After a synchronous active-low reset, both banks hold M=0, N=0, pre code 0 and hold=1. The active bank is 0 and `clk_en` stays low.
- R2: Pre code `p` (0..3) divides by `p+1`. Starting from a bank switch, the bank's ticks fall on cycles `p+1`, `2(p+1)`, and so on.
- R3: With N≠0, each tick adds M to the accumulator. When the sum reaches N or more, N is subtracted and a pulse is issued. Over `t` ticks from a fresh start, `floor(t*M/N)` pulses appear.
- R4: With N=0 the fractional stage is bypassed, and `clk_en` pulses on every tick.
- R5: A write with M greater than N stores M equal to N, so the bank pulses on every tick.
- R6: `act_bank` changes only on the edge that raises `clk_en`, unless the running bank is held. The newly active bank starts with a cleared accumulator and pre-divider.
- R7: While the active bank has hold=1, no pulses are issued. A pending selection then takes effect on the next edge after the select register changes.
- R8: A bank write whose bank index equals `act_bank` is ignored.
- R9: A bank write loads {`wr_m`, `wr_n`, `wr_pre`, `wr_hold`} into bank `wr_bank` on the edge where `wr_en` is high. A select write loads `sel_val` into the select register on the edge where `sel_wr` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Bank write strobe |
| wr_bank | input | 1 | Bank index for the write |
| wr_pre | input | 2 | Pre-divider code (divide by code+1) |
| wr_m | input | 16 | Numerator M |
| wr_n | input | 16 | Denominator N (0 = bypass) |
| wr_hold | input | 1 | Bank hold bit |
| sel_wr | input | 1 | Select register write strobe |
| sel_val | input | 1 | Requested bank |
| clk_en | output | 1 | One-cycle enable pulse stream |
| act_bank | output | 1 | Bank currently driving the output |

## Verification
Several rules hold on every cycle, and the assertions check them:
- the accumulator stays below N;
- the pre-divider count stays within its code;
- a held bank stays silent;
- bypass pulses on every tick;
- switches happen only at pulse boundaries;
- a write aimed at the running bank leaves that bank unchanged.

Other behaviour only the bench scenarios can show. The exact pulse counts over long windows confirm the M/N ratio, the pre-divider factor and the clamping of M. The immediate switch away from a held bank is also a bench check, as is the fact that an ignored write leaves the running pulse train unchanged.

// File: rtl/fcd_pkg.sv
// Shared constants and the bank configuration record of the fractional divider.
package fcd_pkg;
    localparam int CNT_W     = 16;
    localparam int PRE_W     = 2;
    localparam int NUM_BANKS = 2;

    typedef struct packed {
        logic             hold;
        logic             mn_en;
        logic [PRE_W-1:0] pre;
        logic [CNT_W-1:0] m;
        logic [CNT_W-1:0] n;
    } bank_cfg_t;

    localparam bank_cfg_t CFG_RESET = '{hold: 1'b1, mn_en: 1'b0, pre: '0, m: '0, n: '0};

    // Limits the numerator to the denominator so the accumulator stays below N.
    function automatic logic [CNT_W-1:0] clamp_m(input logic [CNT_W-1:0] m,
                                                 input logic [CNT_W-1:0] n);
        return (m > n) ? n : m;
    endfunction
endpackage

// File: rtl/fcd_bank_file.sv
// Two configuration banks of the divider.
// A write lands only when it targets a bank that is not currently active.
// Assumes act_bank is registered in the same clock domain.
module fcd_bank_file
    import fcd_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic                              wr_bank,
    input  logic [PRE_W-1:0]                  wr_pre,
    input  logic [CNT_W-1:0]                  wr_m,
    input  logic [CNT_W-1:0]                  wr_n,
    input  logic                              wr_hold,
    input  logic                              act_bank,
    output bank_cfg_t [NUM_BANKS-1:0]         cfg_q
);
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        bank_cfg_t cfg_r;
        logic      hit;

        assign hit = wr_en && (wr_bank == 1'(b)) && (act_bank != 1'(b));

        // Loads the bank on an accepted write; the M/N enable follows N != 0.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cfg_r <= CFG_RESET;
            end else if (hit) begin
                cfg_r.hold  <= wr_hold;
                cfg_r.mn_en <= (wr_n != '0);
                cfg_r.pre   <= wr_pre;
                cfg_r.m     <= clamp_m(wr_m, wr_n);
                cfg_r.n     <= wr_n;
            end
        end

        assign cfg_q[b] = cfg_r;
    end
endmodule

// File: rtl/fcd_prediv.sv
// Integer pre-divider: raises tick once every (pre+1) cycles.
// The count restarts at zero whenever clr is high.
module fcd_prediv
    import fcd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [PRE_W-1:0] pre,
    output logic             tick,
    output logic [PRE_W-1:0] cnt
);
    assign tick = (cnt == pre);

    // Counts up to the code value, then wraps on the tick.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/fcd_mn_accum.sv
// M/N phase accumulator: on each enabled tick adds M and wraps modulo N.
// Assumes M <= N, which the bank file guarantees by clamping.
module fcd_mn_accum
    import fcd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             step,
    input  logic [CNT_W-1:0] m,
    input  logic [CNT_W-1:0] n,
    output logic             wrap,
    output logic [CNT_W-1:0] acc
);
    logic [CNT_W:0] sum;

    assign sum  = {1'b0, acc} + {1'b0, m};
    assign wrap = (sum >= {1'b0, n});

    // Advances the phase on each step, subtracting N when it wraps.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            acc <= '0;
        end else if (step) begin
            acc <= wrap ? CNT_W'(sum - {1'b0, n}) : sum[CNT_W-1:0];
        end
    end
endmodule

// File: rtl/frac_clk_div.sv
// Dual-bank fractional clock-enable divider.
// The active bank drives a pre-divider and an M/N accumulator.
// Bank switches take effect at a pulse edge, or at once when the running bank is held.
// Assumes all inputs are synchronous to clk.
module frac_clk_div
    import fcd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_bank,
    input  logic [PRE_W-1:0] wr_pre,
    input  logic [CNT_W-1:0] wr_m,
    input  logic [CNT_W-1:0] wr_n,
    input  logic             wr_hold,
    input  logic             sel_wr,
    input  logic             sel_val,
    output logic             clk_en,
    output logic             act_bank
);
    bank_cfg_t [NUM_BANKS-1:0] cfg_q;
    bank_cfg_t                 act_cfg;
    logic                      sel_q;
    logic                      act_q;
    logic                      act_held;
    logic                      tick;
    logic [PRE_W-1:0]          pcnt;
    logic                      wrap;
    logic [CNT_W-1:0]          acc;
    logic                      fire;
    logic                      switch_now;
    logic                      clr;

    assign act_cfg    = cfg_q[act_q];
    assign act_held   = act_cfg.hold;
    assign fire       = !act_held && tick && (!act_cfg.mn_en || wrap);
    assign switch_now = (sel_q != act_q) && (fire || act_held);
    assign clr        = act_held || switch_now;
    assign act_bank   = act_q;

    fcd_bank_file u_banks (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_bank  (wr_bank),
        .wr_pre   (wr_pre),
        .wr_m     (wr_m),
        .wr_n     (wr_n),
        .wr_hold  (wr_hold),
        .act_bank (act_q),
        .cfg_q    (cfg_q)
    );

    fcd_prediv u_prediv (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .pre   (act_cfg.pre),
        .tick  (tick),
        .cnt   (pcnt)
    );

    fcd_mn_accum u_accum (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .step  (tick && act_cfg.mn_en),
        .m     (act_cfg.m),
        .n     (act_cfg.n),
        .wrap  (wrap),
        .acc   (acc)
    );

    // Holds the software-requested bank.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= 1'b0;
        end else if (sel_wr) begin
            sel_q <= sel_val;
        end
    end

    // Moves the active bank at a pulse boundary or away from a held bank.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= 1'b0;
        end else if (switch_now) begin
            act_q <= sel_q;
        end
    end

    // Registers the enable pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_en <= 1'b0;
        end else begin
            clk_en <= fire;
        end
    end
endmodule

// File: rtl/fcd_checker.sv
// Cycle-level properties of the dual-bank divider, bound to frac_clk_div.
module fcd_checker
    import fcd_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             clk_en,
    input logic             act_bank,
    input logic             act_held,
    input logic             mn_en_act,
    input logic             tick,
    input logic [CNT_W-1:0] acc,
    input logic [CNT_W-1:0] n_act,
    input logic [PRE_W-1:0] pcnt,
    input logic [PRE_W-1:0] pre_act,
    input logic             wr_en,
    input logic             wr_bank,
    input bank_cfg_t        cfg0,
    input bank_cfg_t        cfg1
);
    // R2: pre-divider count never passes the active code
    p_prediv_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pcnt <= pre_act);

    // R3: accumulator stays below N while the fractional stage runs
    p_acc_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mn_en_act |-> (acc < n_act));

    // R4: bypass turns every tick into a pulse
    p_bypass_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!act_held && !mn_en_act && tick) |=> clk_en);

    // R6: the active bank moves only at a pulse or away from a held bank
    p_switch_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (act_bank != $past(act_bank)) |-> (clk_en || $past(act_held)));

    // R7: a held active bank issues no pulse
    p_held_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        act_held |=> !clk_en);

    // R8: writes aimed at the running bank leave it unchanged
    p_no_write_act0_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_bank && !act_bank) |=> $stable(cfg0));

    p_no_write_act1_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_bank && act_bank) |=> $stable(cfg1));
endmodule

bind frac_clk_div fcd_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clk_en    (clk_en),
    .act_bank  (act_bank),
    .act_held  (act_held),
    .mn_en_act (act_cfg.mn_en),
    .tick      (tick),
    .acc       (acc),
    .n_act     (act_cfg.n),
    .pcnt      (pcnt),
    .pre_act   (act_cfg.pre),
    .wr_en     (wr_en),
    .wr_bank   (wr_bank),
    .cfg0      (cfg_q[0]),
    .cfg1      (cfg_q[1])
);

// File: tb/sim_frac_clk_div.sv
module sim_frac_clk_div;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 7;
    // Each row: pre code, M, N, window in cycles, expected pulses
    localparam int VEC [NVEC][5] = '{
        '{0, 3, 625, 2500, 12},
        '{3, 1,   6, 2400, 100},
        '{2, 0,   0,  300, 100},
        '{0, 5,  48,  960, 100},
        '{1, 1,   2,  400, 100},
        '{0, 7,   7,   50, 50},
        '{0, 9,   4,   40, 40}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_bank = 1'b0;
    logic [1:0]  wr_pre = '0;
    logic [15:0] wr_m = '0;
    logic [15:0] wr_n = '0;
    logic        wr_hold = 1'b0;
    logic        sel_wr = 1'b0;
    logic        sel_val = 1'b0;
    logic        clk_en;
    logic        act_bank;

    int n_chk = 0;
    int n_err = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    frac_clk_div u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_bank(wr_bank),
        .wr_pre(wr_pre), .wr_m(wr_m), .wr_n(wr_n), .wr_hold(wr_hold),
        .sel_wr(sel_wr), .sel_val(sel_val), .clk_en(clk_en), .act_bank(act_bank)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // R9: one-cycle bank write
    task automatic bank_write(input bit b, input int pre, input int m, input int n, input bit hold);
        @(negedge clk);
        wr_en = 1'b1; wr_bank = b; wr_pre = 2'(pre);
        wr_m = 16'(m); wr_n = 16'(n); wr_hold = hold;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic sel_write(input bit v);
        @(negedge clk);
        sel_wr = 1'b1; sel_val = v;
        @(negedge clk);
        sel_wr = 1'b0;
    endtask

    task automatic count_pulses(input int w, output int c);
        c = 0;
        for (int k = 0; k < w; k++) begin
            @(negedge clk);
            c += int'(clk_en);
        end
    endtask

    task automatic wait_act(input bit target, output bit en_at_flip);
        bit seen;
        seen = 1'b0;
        en_at_flip = 1'b0;
        for (int k = 0; k < 4000 && !seen; k++) begin
            @(negedge clk);
            if (act_bank == target) begin
                seen = 1'b1;
                en_at_flip = clk_en;
            end
        end
        check(seen, "R6 switch timeout", int'(act_bank), int'(target));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL R6 watchdog expired: actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        int c;
        bit en_flip;
        bit tgt;
        string tag;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state, both banks held
        @(negedge clk);
        check(clk_en == 1'b0, "R1 clk_en", int'(clk_en), 0);
        check(act_bank == 1'b0, "R1 act_bank", int'(act_bank), 0);
        count_pulses(30, c);
        check(c == 0, "R1 quiet", c, 0);

        // Vector walk: program the idle bank, select it, count pulses
        for (int i = 0; i < NVEC; i++) begin
            tgt = ~act_bank;
            bank_write(tgt, VEC[i][0], VEC[i][1], VEC[i][2], 1'b0);
            sel_write(tgt);
            wait_act(tgt, en_flip);
            if (i > 0) check(en_flip == 1'b1, "R6 boundary", int'(en_flip), 1);
            count_pulses(VEC[i][3], c);
            if (VEC[i][2] == 0)               tag = "R4";
            else if (VEC[i][1] > VEC[i][2])   tag = "R5";
            else if (VEC[i][0] != 0)          tag = "R2";
            else                              tag = "R3";
            check(c == VEC[i][4], tag, c, VEC[i][4]);
        end

        // R8: write to the running bank (hold, bypass, pre 4) must not land
        tgt = act_bank;
        bank_write(tgt, 3, 0, 0, 1'b1);
        count_pulses(20, c);
        check(c == 20, "R8 active write", c, 20);

        // R7: switch to a held bank, output goes silent
        bank_write(~tgt, 0, 1, 1, 1'b1);
        sel_write(~tgt);
        wait_act(~tgt, en_flip);
        check(en_flip == 1'b1, "R6 boundary into held", int'(en_flip), 1);
        count_pulses(40, c);
        check(c == 0, "R7 held silent", c, 0);

        // R7: leaving a held bank happens on the next edge
        sel_write(tgt);
        check(act_bank == ~tgt, "R7 not yet", int'(act_bank), int'(~tgt));
        @(negedge clk);
        check(act_bank == tgt, "R7 immediate", int'(act_bank), int'(tgt));
        // R8: the earlier ignored write left M/N at every-tick pulsing
        count_pulses(20, c);
        check(c == 20, "R8 config kept", c, 20);

        // R1: reset again mid-run
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        check(act_bank == 1'b0, "R1 act after reset", int'(act_bank), 0);
        count_pulses(20, c);
        check(c == 0, "R1 quiet after reset", c, 0);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule